// File: doc/BRIEF.md
# ECC Error Status and Message Router

This block sits beside a DRAM controller and collects its ECC error pulses. One pulse input flags a correctable single-bit error and another flags an uncorrectable multi-bit error. Each pulse comes with the location of the failing access (rank, bank, row, column) and the ECC syndrome. The block sets a sticky status flag for each error type. Software clears a flag by writing 1 to it. The block also holds one error signature in a log, and the state of the flags decides whether a new error may replace that log.

Three enable registers decide which system message each error type raises: a system-error message, a management-interrupt message or a control-interrupt message. A message goes out as a one-cycle request pulse, and only when a flag goes from 0 to 1. Software reaches every register through a simple configuration port. Writes take effect at the clock edge. Reads are combinational from the selected address.

Register addresses on `cfg_addr_i`:
- 0: status
- 1: system-error enable
- 2: management-interrupt enable
- 3: control-interrupt enable
- 4: logged row
- 5: logged column
- 6: logged rank and bank
- 7: logged syndrome

Top module: `ecc_err_report`

## Requirements
- R1: After reset, every register reads 0 and no message request is active.
- R2: The status register (address 0) has bit 1 as the multi-bit flag and bit 0 as the single-bit flag. Bits 15:2 read 0.
- R3: Status flags are sticky. Writing 1 to a bit of address 0 clears that flag. Writing 0 leaves the flag unchanged.
- R4: A flag is set by its error pulse even when every message enable is 0. In that case no request is raised.
- R5: A request pulse lasts exactly one cycle. It is high in the first cycle in which the flag reads 1, and only when the flag went from 0 to 1. A repeated error while the flag is already set raises nothing.
- R6: The enable registers sit at address 1 (system error), address 2 (management interrupt) and address 3 (control interrupt). In each, bit 1 enables multi-bit errors and bit 0 enables single-bit errors. Bits 15:2 read 0. A flag edge raises every message type whose enable bit for that error type is set.
- R7: The system-error request also requires `serr_glob_en_i` to be high in the cycle the error arrives.
- R8: A single-bit error is logged only while both flags are clear. While the single-bit flag is set, further single-bit errors leave the log unchanged.
- R9: A multi-bit error arriving while the multi-bit flag is clear overwrites the log, even if the single-bit flag is set. While the multi-bit flag is set, the log is frozen, and a single-bit error only sets its flag.
- R10: Single-bit and multi-bit pulses in the same cycle log the presented signature as a multi-bit error and set both flags.
- R11: Clearing only the multi-bit flag while the single-bit flag stays set keeps the log frozen against single-bit errors. The log opens to single-bit errors again only when both flags are clear.
- R12: A clear of a flag in the same cycle as a new error of that type leaves the flag set, raises no request and leaves the log unchanged.
- R13: The log is read-only. Address 4 reads the row, address 5 the column, address 6 reads {rank, bank} with bank in the low bits, and address 7 the syndrome, all zero-extended. Writes to addresses 4 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Read data for `cfg_addr_i` |
| serr_glob_en_i | input | 1 | Global enable for system-error messages |
| sbe_i | input | 1 | Single-bit correctable error pulse |
| mbe_i | input | 1 | Multi-bit uncorrectable error pulse |
| err_rank_i | input | 2 | Rank of the failing access |
| err_bank_i | input | 3 | Bank of the failing access |
| err_row_i | input | 16 | Row of the failing access |
| err_col_i | input | 10 | Column of the failing access |
| err_syn_i | input | 8 | ECC syndrome |
| serr_req_o | output | 1 | System-error message request pulse |
| smi_req_o | output | 1 | Management-interrupt message request pulse |
| sci_req_o | output | 1 | Control-interrupt message request pulse |

## Verification
A flag held in the wrong state shows at the ports in two ways: the status read is wrong in the cycle after the error edge, and a request pulse is missing or repeated at that same edge. A flaw in the freeze logic shows only later, when a following error of the other type either overwrites the signature or fails to. For that reason the bench always reads back the log after error sequences that mix the two types. A faulty clear-versus-set priority shows as a spurious request in the very cycle the write and the error coincide.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;
  localparam int NTYPE  = 2;
  localparam int T_SBE  = 0;
  localparam int T_MBE  = 1;
  localparam int NMSG   = 3;
  localparam int M_SERR = 0;
  localparam int M_SMI  = 1;
  localparam int M_SCI  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT    = 3'd0,
    A_SERR_EN = 3'd1,
    A_SMI_EN  = 3'd2,
    A_SCI_EN  = 3'd3,
    A_LOG_ROW = 3'd4,
    A_LOG_COL = 3'd5,
    A_LOG_RB  = 3'd6,
    A_LOG_SYN = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/ecc_flag_status.sv
module ecc_flag_status
  import ecc_rpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NTYPE-1:0] err_i,
  input  logic [NTYPE-1:0] clr_i,
  output logic [NTYPE-1:0] flag_o,
  output logic [NTYPE-1:0] rise_o
);
  logic [NTYPE-1:0] flag_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | err_i;
  end

  assign rise_o = err_i & ~flag_q;
  assign flag_o = flag_q;

  assert_sticky_mbe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[T_MBE] && !clr_i[T_MBE]) |=> flag_q[T_MBE]);
  assert_sticky_sbe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[T_SBE] && !clr_i[T_SBE]) |=> flag_q[T_SBE]);
  assert_set_mbe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i[T_MBE] |=> flag_q[T_MBE]);
  assert_set_sbe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i[T_SBE] |=> flag_q[T_SBE]);
  assert_rise_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o[T_SBE] |=> !rise_o[T_SBE]);
endmodule

// File: rtl/ecc_msg_route.sv
module ecc_msg_route
  import ecc_rpt_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NMSG-1:0]       en_we_i,
  input  logic [NTYPE-1:0]      en_wdata_i,
  input  logic [NTYPE-1:0]      rise_i,
  input  logic                  serr_glob_en_i,
  output logic [NMSG*NTYPE-1:0] en_o,
  output logic [NMSG-1:0]       msg_o
);
  logic [NMSG-1:0] msg_q;

  for (genvar m = 0; m < NMSG; m++) begin : g_msg
    logic [NTYPE-1:0] en_q;
    logic             hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        en_q <= '0;
      else if (en_we_i[m]) en_q <= en_wdata_i;
    end

    if (m == M_SERR) begin : g_gated
      assign hit = (|(rise_i & en_q)) & serr_glob_en_i;
    end else begin : g_plain
      assign hit = |(rise_i & en_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) msg_q[m] <= 1'b0;
      else         msg_q[m] <= hit;
    end

    assign en_o[m*NTYPE +: NTYPE] = en_q;

    assert_msg_from_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      msg_q[m] |-> $past(|rise_i));
  end

  assign msg_o = msg_q;

  assert_serr_global_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_q[M_SERR] |-> $past(serr_glob_en_i));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  parameter int COL_W  = 10,
  parameter int SYN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic              sbe_flag_i,
  input  logic              mbe_flag_i,
  input  logic [RANK_W-1:0] rank_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [SYN_W-1:0]  syn_i,
  output logic [RANK_W-1:0] rank_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [SYN_W-1:0]  syn_o
);
  localparam int LOG_W = RANK_W + BANK_W + ROW_W + COL_W + SYN_W;

  logic [LOG_W-1:0] log_q;
  logic             cap_mbe, cap_sbe;

  assign cap_mbe = mbe_i & ~mbe_flag_i;
  assign cap_sbe = sbe_i & ~mbe_i & ~sbe_flag_i & ~mbe_flag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                log_q <= '0;
    else if (cap_mbe || cap_sbe) log_q <= {rank_i, bank_i, row_i, col_i, syn_i};
  end

  assign {rank_o, bank_o, row_o, col_o, syn_o} = log_q;

  assert_sbe_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_flag_i && !mbe_i) |=> $stable(log_q));
  assert_mbe_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mbe_flag_i |=> $stable(log_q));
  assert_mbe_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbe_i && !mbe_flag_i) |=> (log_q == $past({rank_i, bank_i, row_i, col_i, syn_i})));
endmodule

// File: rtl/ecc_err_report.sv
module ecc_err_report
  import ecc_rpt_pkg::*;
#(
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  parameter int COL_W  = 10,
  parameter int SYN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic              serr_glob_en_i,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [RANK_W-1:0] err_rank_i,
  input  logic [BANK_W-1:0] err_bank_i,
  input  logic [ROW_W-1:0]  err_row_i,
  input  logic [COL_W-1:0]  err_col_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  output logic              serr_req_o,
  output logic              smi_req_o,
  output logic              sci_req_o
);
  logic [NTYPE-1:0]      err_vec, clr_vec, flag, rise;
  logic [NMSG-1:0]       en_we, msg;
  logic [NMSG*NTYPE-1:0] en_flat;
  logic [RANK_W-1:0]     lg_rank;
  logic [BANK_W-1:0]     lg_bank;
  logic [ROW_W-1:0]      lg_row;
  logic [COL_W-1:0]      lg_col;
  logic [SYN_W-1:0]      lg_syn;
  reg_addr_e             addr;

  assign addr = reg_addr_e'(cfg_addr_i);

  assign err_vec[T_SBE] = sbe_i;
  assign err_vec[T_MBE] = mbe_i;
  assign clr_vec = (cfg_we_i && addr == A_STAT) ? cfg_wdata_i[NTYPE-1:0] : '0;

  assign en_we[M_SERR] = cfg_we_i && addr == A_SERR_EN;
  assign en_we[M_SMI]  = cfg_we_i && addr == A_SMI_EN;
  assign en_we[M_SCI]  = cfg_we_i && addr == A_SCI_EN;

  ecc_flag_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .err_i  (err_vec),
    .clr_i  (clr_vec),
    .flag_o (flag),
    .rise_o (rise)
  );

  ecc_msg_route u_route (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_we_i        (en_we),
    .en_wdata_i     (cfg_wdata_i[NTYPE-1:0]),
    .rise_i         (rise),
    .serr_glob_en_i (serr_glob_en_i),
    .en_o           (en_flat),
    .msg_o          (msg)
  );

  ecc_err_log #(
    .RANK_W (RANK_W),
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .SYN_W  (SYN_W)
  ) u_log (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sbe_i      (sbe_i),
    .mbe_i      (mbe_i),
    .sbe_flag_i (flag[T_SBE]),
    .mbe_flag_i (flag[T_MBE]),
    .rank_i     (err_rank_i),
    .bank_i     (err_bank_i),
    .row_i      (err_row_i),
    .col_i      (err_col_i),
    .syn_i      (err_syn_i),
    .rank_o     (lg_rank),
    .bank_o     (lg_bank),
    .row_o      (lg_row),
    .col_o      (lg_col),
    .syn_o      (lg_syn)
  );

  always_comb begin
    unique case (addr)
      A_STAT:    cfg_rdata_o = REG_W'(flag);
      A_SERR_EN: cfg_rdata_o = REG_W'(en_flat[M_SERR*NTYPE +: NTYPE]);
      A_SMI_EN:  cfg_rdata_o = REG_W'(en_flat[M_SMI*NTYPE +: NTYPE]);
      A_SCI_EN:  cfg_rdata_o = REG_W'(en_flat[M_SCI*NTYPE +: NTYPE]);
      A_LOG_ROW: cfg_rdata_o = REG_W'(lg_row);
      A_LOG_COL: cfg_rdata_o = REG_W'(lg_col);
      A_LOG_RB:  cfg_rdata_o = REG_W'({lg_rank, lg_bank});
      A_LOG_SYN: cfg_rdata_o = REG_W'(lg_syn);
      default:   cfg_rdata_o = '0;
    endcase
  end

  assign serr_req_o = msg[M_SERR];
  assign smi_req_o  = msg[M_SMI];
  assign sci_req_o  = msg[M_SCI];

  assert_req_needs_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serr_req_o || smi_req_o || sci_req_o) |-> (flag != '0));
endmodule

// File: tb/sim_ecc_err_report.sv
`timescale 1ns/1ps
module sim_ecc_err_report;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = 3'd0;
  logic [15:0] cfg_wdata_i = 16'd0;
  logic [15:0] cfg_rdata_o;
  logic        serr_glob_en_i = 1'b1;
  logic        sbe_i = 1'b0, mbe_i = 1'b0;
  logic [1:0]  err_rank_i = '0;
  logic [2:0]  err_bank_i = '0;
  logic [15:0] err_row_i = '0;
  logic [9:0]  err_col_i = '0;
  logic [7:0]  err_syn_i = '0;
  logic        serr_req_o, smi_req_o, sci_req_o;

  typedef struct {
    string       tag;
    bit          is_msg;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;

  always #2 clk_i = ~clk_i;

  ecc_err_report u0 (.*);

  // monitor
  always @(negedge clk_i) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = q.pop_front();
      act = it.is_msg ? {13'd0, sci_req_o, smi_req_o, serr_req_o} : cfg_rdata_o;
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [15:0] e_row(int k); return 16'(16'h1000 + k); endfunction
  function automatic logic [15:0] e_col(int k); return 16'(10'(k * 3 + 7)); endfunction
  function automatic logic [15:0] e_rb(int k);  return 16'({2'(k >> 1), 3'(k + 5)}); endfunction
  function automatic logic [15:0] e_syn(int k); return 16'(8'(k ^ 8'h5A)); endfunction

  // one driven cycle; returns in the cycle after the capturing edge
  task automatic cyc(input logic we, input logic [2:0] a, input logic [15:0] d,
                     input logic s, input logic m, input int k);
    @(posedge clk_i); #1;
    cfg_we_i = we; cfg_addr_i = a; cfg_wdata_i = d;
    sbe_i = s; mbe_i = m;
    err_row_i = e_row(k); err_col_i = e_col(k)[9:0];
    {err_rank_i, err_bank_i} = e_rb(k)[4:0]; err_syn_i = e_syn(k)[7:0];
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0; sbe_i = 1'b0; mbe_i = 1'b0;
  endtask

  task automatic chk_msg(input logic [2:0] exp, input string tag);
    q.push_back('{tag, 1'b1, {13'd0, exp}});
    @(negedge clk_i); #1;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk_i); #1;
    cfg_addr_i = a;
    q.push_back('{tag, 1'b0, exp});
    @(negedge clk_i); #1;
  endtask

  task automatic chk_log(input int k, input string tag);
    chk_reg(3'd4, e_row(k), tag);
    chk_reg(3'd5, e_col(k), tag);
    chk_reg(3'd6, e_rb(k), tag);
    chk_reg(3'd7, e_syn(k), tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 0);
  endtask

  task automatic err(input logic s, input logic m, input int k);
    cyc(1'b0, 3'd0, 16'd0, s, m, k);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1
    chk_msg(3'b000, "R1 no request after reset");
    for (int a = 0; a < 8; a++) chk_reg(3'(a), 16'd0, "R1 register reset");
    // R6 enable layout
    wr(3'd1, 16'hFFFF);
    chk_reg(3'd1, 16'h0003, "R6 serr enable reserved bits");
    wr(3'd1, 16'h0000);
    // R4 flag set with no enables, R8 first capture
    err(1'b1, 1'b0, 1);
    chk_msg(3'b000, "R4 no request while disabled");
    chk_reg(3'd0, 16'h0001, "R4 R2 single-bit flag in bit 0");
    chk_log(1, "R8 first single-bit capture");
    err(1'b1, 1'b0, 2);
    chk_log(1, "R8 log held by single-bit flag");
    // R3 write-0 and write to other bit
    wr(3'd0, 16'h0000);
    chk_reg(3'd0, 16'h0001, "R3 write 0 no effect");
    wr(3'd0, 16'hFFFC);
    chk_reg(3'd0, 16'h0001, "R3 reserved bits no effect");
    // routing: serr<-sbe, smi<-mbe
    wr(3'd1, 16'h0001);
    wr(3'd2, 16'h0002);
    chk_reg(3'd2, 16'h0002, "R6 smi enable readback");
    err(1'b0, 1'b1, 3);
    chk_msg(3'b010, "R6 multi-bit routed to smi only");
    chk_msg(3'b000, "R5 pulse lasts one cycle");
    chk_reg(3'd0, 16'h0003, "R2 both flags");
    chk_log(3, "R9 multi-bit overwrites single-bit log");
    err(1'b1, 1'b0, 4);
    chk_msg(3'b000, "R5 no request while flag set");
    wr(3'd0, 16'h0001);
    chk_reg(3'd0, 16'h0002, "R3 clear single-bit flag");
    err(1'b1, 1'b0, 5);
    chk_msg(3'b001, "R5 new edge routed to serr");
    chk_reg(3'd0, 16'h0003, "R9 single-bit sets flag under multi-bit");
    chk_log(3, "R9 log frozen by multi-bit flag");
    // R11
    wr(3'd0, 16'h0002);
    chk_reg(3'd0, 16'h0001, "R11 only multi-bit cleared");
    err(1'b1, 1'b0, 6);
    chk_log(3, "R11 single-bit still frozen");
    err(1'b0, 1'b1, 7);
    chk_msg(3'b010, "R11 multi-bit edge after clear");
    chk_log(7, "R11 multi-bit captured again");
    wr(3'd0, 16'h0003);
    chk_reg(3'd0, 16'h0000, "R3 clear both");
    err(1'b1, 1'b0, 8);
    chk_msg(3'b001, "R8 single-bit edge after full clear");
    chk_log(8, "R8 log open after both clear");
    // R12 clear and error of same type together
    cyc(1'b1, 3'd0, 16'h0001, 1'b1, 1'b0, 9);
    chk_msg(3'b000, "R12 no request on clear+set");
    chk_reg(3'd0, 16'h0001, "R12 flag stays set");
    chk_log(8, "R12 log unchanged");
    // R7
    wr(3'd0, 16'h0003);
    serr_glob_en_i = 1'b0;
    err(1'b1, 1'b0, 10);
    chk_msg(3'b000, "R7 serr blocked by global enable");
    chk_reg(3'd0, 16'h0001, "R7 flag still set");
    serr_glob_en_i = 1'b1;
    // R10 simultaneous
    wr(3'd0, 16'h0003);
    wr(3'd3, 16'h0003);
    err(1'b1, 1'b1, 11);
    chk_msg(3'b111, "R10 R6 both edges fan out");
    chk_reg(3'd0, 16'h0003, "R10 both flags set");
    chk_log(11, "R10 signature logged");
    // R13 read-only log
    wr(3'd4, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    chk_log(11, "R13 log writes ignored");
    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule